// File: doc/BRIEF.md
# Signed-Count Barrel Shifter

This block shifts a 64-bit word by a count in one clock. It offers three shift kinds: logical, arithmetic and circular. Each kind can run in one of two ways. In the signed-count way, the sign of a full-width two's-complement count picks the direction: a non-negative count shifts left and a negative count shifts right by its magnitude. In the fixed-direction way, the caller names left or right and the count is read as an unsigned magnitude.

Requests enter on a valid/ready stream that carries the operand, the count, the kind and the mode. Results leave on a second valid/ready stream one cycle after they are accepted. There is a single register stage between the two streams.

Back-pressure follows one rule: a new request is taken whenever the output slot is empty or is being drained in the same cycle. A result that is not taken stays on the output with valid held high and the data unchanged.

Top module: `shf_unit`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. An accepted request gives its result on `out_data` with `out_valid` high in the next cycle. Results leave in acceptance order. While `out_valid` is 1 and `out_ready` is 0, both `out_valid` and `out_data` hold.
- R3: With `in_mode` 00 or 11 (signed count), `in_count` bit 63 equal to 0 shifts left by the count. Bit 63 equal to 1 shifts right by the two's-complement magnitude of the count.
- R4: With `in_mode` 01 the shift goes left, and with `in_mode` 10 it goes right. In both cases the count is an unsigned magnitude.
- R5: With `in_kind` 00 or 11 (logical), vacated bit positions fill with zeros.
- R6: With `in_kind` 01 (arithmetic) and a right shift, vacated positions fill with operand bit 63.
- R7: With `in_kind` 01 and a left shift, result bit 63 equals operand bit 63. Bits 62..0 are operand bits 62..0 shifted left, with zeros filling.
- R8: With `in_kind` 10 (circular), bits leaving one end re-enter at the other. The magnitude is taken modulo 64, which means only its low six bits count.
- R9: For a magnitude of 64 or more:
  - a logical shift gives 0;
  - a right arithmetic shift gives 64 copies of operand bit 63;
  - a left arithmetic shift gives operand bit 63 followed by 63 zeros.
- R10: A count of zero returns the operand unchanged, whatever the mode and kind.
- R11: In a signed-count mode, the most negative count (only bit 63 set) shifts right by 2^63. A logical shift then gives 0, and a circular shift returns the operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_data | input | 64 | Operand |
| in_count | input | 64 | Shift count (signed or unsigned, as set by mode) |
| in_kind | input | 2 | 00/11 logical, 01 arithmetic, 10 circular |
| in_mode | input | 2 | 00/11 signed count, 01 fixed left, 10 fixed right |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Shifted word |

## Verification
Two things can happen in the same cycle: a held result is handed to the consumer, and a fresh request is accepted into the slot it frees. The bench provokes this by keeping requests flowing while it toggles `out_ready` at random. Each cycle it compares the output against a queue of expected words built from a behavioural shift model. If a request is lost, doubled or reordered, or if a stalled word changes, the mismatch appears on the next handshake or in the hold check.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
package shf_pkg;
  typedef enum logic [1:0] {
    KIND_LOGIC = 2'b00,
    KIND_ARITH = 2'b01,
    KIND_ROTATE = 2'b10,
    KIND_LOGIC_ALT = 2'b11
  } shf_kind_e;

  typedef enum logic [1:0] {
    MODE_SIGNED = 2'b00,
    MODE_LEFT = 2'b01,
    MODE_RIGHT = 2'b10,
    MODE_SIGNED_ALT = 2'b11
  } shf_mode_e;
endpackage

// File: rtl/shf_count_decode.sv
`timescale 1ns/1ps
module shf_count_decode #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SHW = 6
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       mode,
  output logic             go_right,
  output logic [SHW-1:0]   amt,
  output logic             sat
);
  import shf_pkg::*;

  logic             signed_mode;
  logic             negative;
  logic [CNT_W-1:0] mag;

  always_comb begin
    signed_mode = (shf_mode_e'(mode) == MODE_SIGNED) || (shf_mode_e'(mode) == MODE_SIGNED_ALT);
    negative    = signed_mode & count[CNT_W-1];
    mag         = negative ? (~count + {{(CNT_W-1){1'b0}}, 1'b1}) : count;
    go_right    = signed_mode ? negative : (shf_mode_e'(mode) == MODE_RIGHT);
    amt         = mag[SHW-1:0];
    sat         = |mag[CNT_W-1:SHW];
  end
endmodule

// File: rtl/shf_barrel.sv
`timescale 1ns/1ps
module shf_barrel #(
  parameter int unsigned W = 64,
  parameter int unsigned SHW = 6
) (
  input  logic [W-1:0]   data,
  input  logic [SHW-1:0] amt,
  input  logic           go_right,
  input  logic           arith,
  input  logic           rotate,
  input  logic           sat,
  output logic [W-1:0]   result
);
  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] o;
    for (int b = 0; b < int'(W); b++) o[b] = v[W-1-b];
    return o;
  endfunction

  logic         sign;
  logic         fill;
  logic [W-1:0] st [SHW+1];
  logic [W-1:0] raw;

  assign sign  = data[W-1];
  assign fill  = arith & go_right & sign;
  assign st[0] = go_right ? data : flip(data);

  for (genvar i = 0; i < int'(SHW); i++) begin : g_stage
    localparam int unsigned S = 1 << i;
    logic [S-1:0] ins;
    assign ins       = rotate ? st[i][S-1:0] : {S{fill}};
    assign st[i+1]   = amt[i] ? {ins, st[i][W-1:S]} : st[i];
  end

  always_comb begin
    raw = go_right ? st[SHW] : flip(st[SHW]);
    if (arith && !go_right && !rotate) raw[W-1] = sign;
    if (sat && !rotate) begin
      if (!arith)        raw = '0;
      else if (go_right) raw = {W{sign}};
      else               raw = {sign, {(W-1){1'b0}}};
    end
    result = raw;
  end
endmodule

// File: rtl/shf_out_stage.sv
`timescale 1ns/1ps
module shf_out_stage #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end
endmodule

// File: rtl/shf_unit.sv
`timescale 1ns/1ps
module shf_unit #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [1:0]        in_kind,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  import shf_pkg::*;
  localparam int unsigned SHW = $clog2(DATA_W);

  logic              go_right;
  logic [SHW-1:0]    amt;
  logic              sat;
  logic              arith;
  logic              rotate;
  logic [DATA_W-1:0] shifted;

  assign arith  = (shf_kind_e'(in_kind) == KIND_ARITH);
  assign rotate = (shf_kind_e'(in_kind) == KIND_ROTATE);

  shf_count_decode #(.CNT_W(CNT_W), .SHW(SHW)) u_dec (
    .count(in_count), .mode(in_mode), .go_right(go_right), .amt(amt), .sat(sat)
  );

  shf_barrel #(.W(DATA_W), .SHW(SHW)) u_bar (
    .data(in_data), .amt(amt), .go_right(go_right), .arith(arith),
    .rotate(rotate), .sat(sat), .result(shifted)
  );

  shf_out_stage #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(shifted), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/shf_unit_chk.sv
`timescale 1ns/1ps
module shf_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [CNT_W-1:0]  in_count,
  input logic [1:0]        in_kind,
  input logic [1:0]        in_mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  localparam int unsigned SHW = $clog2(DATA_W);
  logic fire;
  assign fire = in_valid && in_ready;

  always @(posedge clk) begin
    if (!rst_n) p_reset_idle_r1: assert (!out_valid);
  end

  p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_count == '0) |=> (out_data == $past(in_data)));

  p_logic_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == 2'b00 && in_mode == 2'b10 && |in_count[CNT_W-1:SHW]) |=> (out_data == '0));

  p_rot_whole_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == 2'b10 && in_mode == 2'b01 && in_count[SHW-1:0] == '0)
      |=> (out_data == $past(in_data)));

  p_arith_left_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == 2'b01 && in_mode == 2'b01) |=> (out_data[DATA_W-1] == $past(in_data[DATA_W-1])));
endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_count(in_count), .in_kind(in_kind), .in_mode(in_mode),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_shf_unit.sv
`timescale 1ns/1ps
module sim_shf_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [63:0] in_data, in_count, out_data;
  logic [1:0]  in_kind, in_mode;

  shf_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_count(in_count), .in_kind(in_kind), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          hold_pend = 0;
  logic [63:0] held;

  localparam logic [63:0] MINC = 64'h8000_0000_0000_0000;

  function automatic logic [63:0] model(logic [63:0] x, logic [63:0] c, logic [1:0] k, logic [1:0] m);
    logic right;
    logic [63:0] mag;
    int r;
    if (m == 2'b01)      begin right = 0; mag = c; end
    else if (m == 2'b10) begin right = 1; mag = c; end
    else if (c[63])      begin right = 1; mag = -c; end
    else                 begin right = 0; mag = c; end
    if (k == 2'b10) begin
      r = int'(mag % 64);
      if (right) return (x >> r) | (x << (64 - r));
      return (x << r) | (x >> (64 - r));
    end
    if (k == 2'b01) begin
      if (right) return 64'($signed(x) >>> mag);
      return {x[63], 63'(x[62:0] << mag)};
    end
    return right ? (x >> mag) : (x << mag);
  endfunction

  function automatic string tag_of(logic [63:0] c, logic [1:0] k, logic [1:0] m);
    logic bi;
    logic right;
    logic [63:0] mag;
    bi = (m == 2'b00) || (m == 2'b11);
    right = bi ? c[63] : (m == 2'b10);
    mag = (bi && c[63]) ? -c : c;
    if (c == 0) return "R10";
    if (bi && c == MINC) return "R11";
    if (mag >= 64 && k != 2'b10) return "R9";
    if (k == 2'b10) return "R8";
    if (k == 2'b01) return right ? "R6" : "R7";
    return bi ? "R3" : "R4 R5";
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [63:0] d, input logic [63:0] c,
                      input logic [1:0] k, input logic [1:0] m, input logic ordy,
                      output bit taken);
    @(negedge clk);
    in_valid = v; in_data = d; in_count = c; in_kind = k; in_mode = m; out_ready = ordy;
    #1;
    if (hold_pend) check(out_valid === 1'b1 && out_data === held, "R2 hold", out_data, held);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R2 extra result", out_data, 64'h0);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data === e, t, out_data, e);
      end
    end
    hold_pend = out_valid && !out_ready;
    held = out_data;
    taken = v && in_ready;
    if (taken) begin
      exp_q.push_back(model(d, c, k, m));
      tag_q.push_back(tag_of(c, k, m));
    end
  endtask

  task automatic send(input logic [63:0] d, input logic [63:0] c, input logic [1:0] k, input logic [1:0] m);
    bit t;
    t = 0;
    while (!t) step(1'b1, d, c, k, m, 1'b1, t);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] rnd_count();
    int s;
    s = int'($urandom() % 8);
    case (s)
      0: return 64'd0;
      1: return MINC;
      2: return rnd64();
      3: return ($urandom() % 2) ? 64'd64 : -64'sd64;
      default: return 64'($signed(int'($urandom() % 141) - 70));
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit t;
    rst_n = 0; in_valid = 0; in_data = 0; in_count = 0; in_kind = 0; in_mode = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R1 valid in reset", {63'b0, out_valid}, 64'h0);
    @(negedge clk); rst_n = 1; #1;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1 after release", {62'b0, out_valid, in_ready}, 64'h1);

    // R10 zero count in several modes and kinds
    send(64'h0123_4567_89AB_CDEF, 64'd0, 2'b00, 2'b00);
    send(64'hF123_4567_89AB_CDEF, 64'd0, 2'b01, 2'b10);
    send(64'hDEAD_BEEF_0000_0001, 64'd0, 2'b10, 2'b01);
    // R3 signed-count direction
    send(64'h8000_0000_0000_0001, 64'd4, 2'b00, 2'b00);
    send(64'h8000_0000_0000_0001, -64'sd4, 2'b00, 2'b00);
    send(64'h00FF_0000_0000_FF00, -64'sd1, 2'b11, 2'b11);
    // R4 R5 fixed direction, logical fill
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 2'b00, 2'b01);
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 2'b11, 2'b10);
    // R6 arithmetic right
    send(64'h8400_0000_0000_0000, 64'd4, 2'b01, 2'b10);
    send(64'h8400_0000_0000_0000, -64'sd5, 2'b01, 2'b00);
    // R7 arithmetic left
    send(64'hC000_0000_0000_0003, 64'd1, 2'b01, 2'b01);
    send(64'h4000_0000_0000_0003, 64'd63, 2'b01, 2'b01);
    // R8 circular, count modulo 64
    send(64'h0000_0000_0000_0001, -64'sd1, 2'b10, 2'b00);
    send(64'h1234_5678_9ABC_DEF0, 64'd68, 2'b10, 2'b01);
    send(64'h1234_5678_9ABC_DEF0, 64'd64, 2'b10, 2'b10);
    // R9 saturation
    send(64'hFFFF_0000_FFFF_0000, 64'd64, 2'b00, 2'b01);
    send(64'hFFFF_0000_FFFF_0000, 64'd200, 2'b00, 2'b10);
    send(64'h8000_0000_0000_1234, 64'd64, 2'b01, 2'b10);
    send(64'h8000_0000_0000_1234, 64'd100, 2'b01, 2'b01);
    send(64'h7000_0000_0000_1234, -64'sd64, 2'b01, 2'b00);
    // R11 most negative count
    send(64'hA5A5_A5A5_A5A5_A5A5, MINC, 2'b00, 2'b00);
    send(64'hA5A5_A5A5_A5A5_A5A5, MINC, 2'b10, 2'b00);
    send(64'hA5A5_A5A5_A5A5_A5A5, MINC, 2'b01, 2'b11);

    // R2 random traffic with back-pressure, all modes and kinds
    for (int i = 0; i < 3000; i++) begin
      step(($urandom() % 5) != 0, rnd64(), rnd_count(), 2'($urandom()), 2'($urandom()),
           ($urandom() % 5) < 3, t);
    end

    for (int i = 0; i < 4; i++) step(1'b0, 64'h0, 64'h0, 2'b00, 2'b00, 1'b1, t);
    check(exp_q.size() == 0 && out_valid === 1'b0, "R2 drained", 64'(exp_q.size()), 64'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule